// File: doc/BRIEF.md
# Early Capture Hold Gate

This block lets a boundary-scan chain sample its pins at a moment picked by the tester, rather than at the later capture-DR edge. While the TAP sits in update-DR, the TMS line is high and the TAP does not look at it. The tester may drive a falling edge on TMS at any chosen point in that interval. That falling edge freezes a bank of hold stages placed in front of the capture flops. The frozen values stay put until the normal capture-DR strobe has taken them. Shift-DR then releases the bank. The result is that a test can measure a propagation delay shorter than one TCK period. It can also measure a longer delay, if the tester withholds TCK rising edges so that the TAP stays in update-DR before it drops TMS.

The block runs on a sampling clock that is fast compared with TCK, and it sees TMS and the TAP state flags as synchronous levels. A set/reset flag records the qualifying falling edge. That flag, combined through a NAND with the early-capture instruction bit, gives the active-low hold signal. While the hold signal is high, every hold stage is transparent, so the chain behaves like a standard one. An output cell feeds two entries of the bank: its internal input and its pin. Both entries freeze in the same cycle, so the delay between the two points can be compared.

Top module: `ec_capture_gate`

## Requirements
- R1: After reset, `ecHoldN` is 1 and `heldBits` equals `pinBits`. Both stay that way until a qualifying TMS fall.
- R2: A qualifying TMS fall sets the hold. A qualifying fall is a cycle in which `tms` is 0, `tms` was 1 in the previous cycle, `updateDr` is 1 and `shiftDr` is 0. If `ecEnable` is 1, then from the next cycle `ecHoldN` is 0 and `heldBits` equals the `pinBits` value of the fall cycle.
- R3: While `ecHoldN` is 0, `heldBits` does not change, whatever `pinBits` does.
- R4: A cycle with `shiftDr` at 1 clears the hold. From the next cycle `ecHoldN` is 1 and `heldBits` follows `pinBits` again.
- R5: While `ecEnable` is 0, `ecHoldN` is 1 and `heldBits` equals `pinBits`, even after a qualifying fall.
- R6: A TMS fall while `updateDr` is 0 has no effect on the hold.
- R7: If TMS stays high through update-DR, the bank stays transparent, as in a standard capture.
- R8: Once the hold is set, further TMS falls before it is cleared do not reload the bank.
- R9: When `shiftDr` and a TMS fall occur in the same cycle, the clear wins and the bank stays transparent.
- R10: All `WIDTH` bits freeze in the same cycle. This means the internal and pin entries of an output cell are sampled at one instant.
- R11: A TMS fall that comes after any number of cycles spent in update-DR with TMS high still sets the hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock of the block |
| rstN | input | 1 | Asynchronous reset, active low |
| tms | input | 1 | Raw TMS line |
| updateDr | input | 1 | TAP is in update-DR |
| shiftDr | input | 1 | TAP is in shift-DR |
| ecEnable | input | 1 | Early-capture instruction bit |
| pinBits | input | WIDTH | Live pin and internal sample points |
| heldBits | output | WIDTH | Values presented to the capture flops |
| ecHoldN | output | 1 | Early-capture hold, active low |

## Verification
The hardest situation to reach is a TMS fall that arrives while the hold is already set. Only a second fall inside update-DR, before any shift-DR, reaches it. The stimulus reaches it by freezing the bank, leaving update-DR, changing the pins, and then re-entering update-DR and dropping TMS again. It then checks that the originally frozen value survives. The bench also sets up a coincident shift-DR and fall, a fall made while the enable is low, and a long dwell in update-DR before the fall.

// File: rtl/ec_pkg.sv
package ec_pkg;
  // Strobes from the control into the hold datapath
  typedef struct packed {
    logic grab;   // load the hold stages this cycle
    logic holdN;  // 0: present held values, 1: transparent
  } ecStrobe_t;
endpackage

// File: rtl/ec_control.sv
module ec_control
  import ec_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      tms,
  input  logic      updateDr,
  input  logic      shiftDr,
  input  logic      ecEnable,
  output ecStrobe_t strobe
);
  logic tmsPrev;
  logic latched;
  logic fallSeen;

  // TMS idles high, so the history register resets to 1
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) tmsPrev <= 1'b1;
    else       tmsPrev <= tms;
  end

  assign fallSeen = tmsPrev & ~tms & updateDr;

  // Set/reset flag; the clear from shift-DR dominates
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         latched <= 1'b0;
    else if (shiftDr)  latched <= 1'b0;
    else if (fallSeen) latched <= 1'b1;
  end

  always_comb begin
    strobe.grab  = fallSeen & ~latched & ~shiftDr;
    strobe.holdN = ~(latched & ecEnable);
  end
endmodule

// File: rtl/ec_datapath.sv
module ec_datapath
  import ec_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  ecStrobe_t        strobe,
  input  logic [WIDTH-1:0] pinBits,
  output logic [WIDTH-1:0] heldBits
);
  logic [WIDTH-1:0] heldQ;

  for (genvar i = 0; i < WIDTH; i++) begin : gHold
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)            heldQ[i] <= 1'b0;
      else if (strobe.grab) heldQ[i] <= pinBits[i];
    end
    assign heldBits[i] = strobe.holdN ? pinBits[i] : heldQ[i];
  end
endmodule

// File: rtl/ec_capture_gate.sv
module ec_capture_gate
  import ec_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             tms,
  input  logic             updateDr,
  input  logic             shiftDr,
  input  logic             ecEnable,
  input  logic [WIDTH-1:0] pinBits,
  output logic [WIDTH-1:0] heldBits,
  output logic             ecHoldN
);
  ecStrobe_t strobe;

  ec_control uCtrl (
    .clk(clk), .rstN(rstN), .tms(tms), .updateDr(updateDr),
    .shiftDr(shiftDr), .ecEnable(ecEnable), .strobe(strobe)
  );

  ec_datapath #(.WIDTH(WIDTH)) uData (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .pinBits(pinBits), .heldBits(heldBits)
  );

  assign ecHoldN = strobe.holdN;
endmodule

// File: rtl/ec_capture_gate_checker.sv
module ec_capture_gate_checker #(
  parameter int WIDTH = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic             tms,
  input logic             updateDr,
  input logic             shiftDr,
  input logic             ecEnable,
  input logic [WIDTH-1:0] pinBits,
  input logic [WIDTH-1:0] heldBits,
  input logic             ecHoldN
);
  // R1: an open hold shows the live pins
  a_r1_transparent: assert property (@(posedge clk) disable iff (!rstN)
    ecHoldN |-> heldBits == pinBits);

  // R2 / R10: a qualifying fall freezes every bit at once
  a_r2_grab: assert property (@(posedge clk) disable iff (!rstN)
    (ecEnable && $past(ecEnable) && ecHoldN && updateDr && !shiftDr && $fell(tms))
    |=> (!ecEnable || (!ecHoldN && heldBits == $past(pinBits))));

  // R3: the held value is stable until cleared
  a_r3_stable: assert property (@(posedge clk) disable iff (!rstN)
    (!ecHoldN && !shiftDr) |=> (!ecEnable || (!ecHoldN && $stable(heldBits))));

  // R4: shift-DR releases the hold
  a_r4_release: assert property (@(posedge clk) disable iff (!rstN)
    shiftDr |=> ecHoldN);

  // R5: no hold without the enable bit
  a_r5_disabled: assert property (@(posedge clk) disable iff (!rstN)
    !ecEnable |-> ecHoldN);
endmodule

bind ec_capture_gate ec_capture_gate_checker #(.WIDTH(WIDTH)) uCheck (.*);

// File: tb/ec_capture_gate_test.sv
module ec_capture_gate_test;
  localparam int WIDTH = 8;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             tms = 1'b1;
  logic             updateDr = 1'b0;
  logic             shiftDr = 1'b0;
  logic             ecEnable = 1'b0;
  logic [WIDTH-1:0] pinBits = '0;
  logic [WIDTH-1:0] heldBits;
  logic             ecHoldN;

  int testsRun = 0;
  int testsFailed = 0;

  always #10 clk = ~clk;

  ec_capture_gate #(.WIDTH(WIDTH)) uut (
    .clk(clk), .rstN(rstN), .tms(tms), .updateDr(updateDr),
    .shiftDr(shiftDr), .ecEnable(ecEnable), .pinBits(pinBits),
    .heldBits(heldBits), .ecHoldN(ecHoldN)
  );

  // Row fields: tms, upd, shf, en, pins[8], expHoldN, expHeld[8], req number
  localparam int ROWS = 15;
  typedef struct packed {
    logic       tms;
    logic       upd;
    logic       shf;
    logic       en;
    logic [7:0] pins;
    logic       expHoldN;
    logic [7:0] expHeld;
    logic [3:0] req;
  } row_t;

  localparam row_t TABLE [ROWS] = '{
    '{1'b1,1'b0,1'b0,1'b1,8'hA5,1'b1,8'hA5,4'd1},  // R1 idle
    '{1'b0,1'b0,1'b0,1'b1,8'h3C,1'b1,8'h3C,4'd6},  // R6 fall outside update-DR
    '{1'b1,1'b1,1'b0,1'b1,8'h11,1'b1,8'h11,4'd7},  // R7 update-DR, TMS high
    '{1'b0,1'b1,1'b0,1'b1,8'h5A,1'b0,8'h5A,4'd2},  // R2 / R10 grab
    '{1'b1,1'b0,1'b0,1'b1,8'hFF,1'b0,8'h5A,4'd3},  // R3 pins change
    '{1'b0,1'b1,1'b0,1'b1,8'h00,1'b0,8'h5A,4'd8},  // R8 second fall ignored
    '{1'b1,1'b0,1'b1,1'b1,8'h77,1'b1,8'h77,4'd4},  // R4 release
    '{1'b0,1'b1,1'b0,1'b0,8'h81,1'b1,8'h81,4'd5},  // R5 fall, enable low
    '{1'b1,1'b0,1'b1,1'b0,8'h42,1'b1,8'h42,4'd5},  // R5 clear
    '{1'b0,1'b1,1'b1,1'b1,8'h99,1'b1,8'h99,4'd9},  // R9 clear wins
    '{1'b1,1'b1,1'b0,1'b1,8'h12,1'b1,8'h12,4'd11}, // R11 dwell
    '{1'b1,1'b1,1'b0,1'b1,8'h13,1'b1,8'h13,4'd11}, // R11 dwell
    '{1'b0,1'b1,1'b0,1'b1,8'hC3,1'b0,8'hC3,4'd11}, // R11 late fall
    '{1'b1,1'b0,1'b0,1'b1,8'h00,1'b0,8'hC3,4'd3},  // R3 still held
    '{1'b1,1'b0,1'b1,1'b1,8'hE7,1'b1,8'hE7,4'd4}   // R4 release
  };

  task automatic check(input string tag, input logic [WIDTH:0] act, input logic [WIDTH:0] exp);
    testsRun++;
    if (act !== exp) begin
      testsFailed++;
      $display("FAIL %s: holdN/held actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic drive(input row_t r);
    tms = r.tms; updateDr = r.upd; shiftDr = r.shf; ecEnable = r.en; pinBits = r.pins;
  endtask

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    testsRun++;
    testsFailed++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin : main
    ecEnable = 1'b1;
    pinBits = 8'h6E;
    repeat (2) @(negedge clk);
    // R1: reset state is transparent
    check("R1 in reset", {ecHoldN, heldBits}, {1'b1, 8'h6E});
    rstN = 1'b1;
    @(negedge clk);
    check("R1 after reset", {ecHoldN, heldBits}, {1'b1, 8'h6E});

    for (int i = 0; i < ROWS; i++) begin
      drive(TABLE[i]);
      @(negedge clk);
      check($sformatf("R%0d row %0d", TABLE[i].req, i),
            {ecHoldN, heldBits}, {TABLE[i].expHoldN, TABLE[i].expHeld});
    end

    // R10: independent halves of the bank (internal point and pin point)
    tms = 1'b1; updateDr = 1'b1; shiftDr = 1'b0; pinBits = 8'hF0;
    @(negedge clk);
    tms = 1'b0; pinBits = 8'h0F;
    @(negedge clk);
    pinBits = 8'hAA;
    @(negedge clk);
    check("R10 both halves frozen together", {ecHoldN, heldBits}, {1'b0, 8'h0F});

    // R1: reset during a hold reopens the bank
    rstN = 1'b0;
    @(negedge clk);
    check("R1 reset clears hold", {ecHoldN, heldBits}, {1'b1, 8'hAA});
    rstN = 1'b1; tms = 1'b1; updateDr = 1'b0;
    @(negedge clk);
    pinBits = 8'h55;
    @(negedge clk);
    check("R1 transparent after reset", {ecHoldN, heldBits}, {1'b1, 8'h55});

    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end
endmodule